// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block collects up to 32 primary interrupt sources and a second layer of 15 sub-sources. It produces one interrupt request line for the processor. The sub-sources come in fixed groups, and each group stands behind a single primary bit, its parent. A parent is requested only while some sub-source in its group is pending and not hidden by the sub-mask.

At the primary level the block keeps three registers: a latch of raw requests (source-pending), a mask, and a one-hot selection register (interrupt-pending). Each cycle in which the selection register is empty, the lowest-numbered pending source that is not masked is moved into it. The processor request is the OR of the selection register.

Software reads and writes the registers through a simple single-cycle port. It clears pending bits by writing ones. For a grouped source, software clears the sub-pending bit first, then the parent bit in source-pending, then the parent bit in interrupt-pending.

Top module: `casc_intc`

## Requirements
- R1: After reset, the primary mask reads all ones, the sub-mask reads all ones (bits 14:0), source-pending, interrupt-pending and sub-pending read zero, and `irq_o` is low.
- R2: Writing a one to a bit of source-pending (address 0), interrupt-pending (address 2) or sub-pending (address 3) clears that bit. Writing a zero leaves it unchanged.
- R3: A set bit in the primary mask (address 1) keeps that source out of interrupt-pending and off `irq_o`, while source-pending still records it. Clearing the mask bit lets the source reach interrupt-pending.
- R4: A direct source that is not in `LEVEL_SRC` sets its pending bit once per rising edge of its line. A source in `LEVEL_SRC` sets its bit every cycle its line is high, so it is set again after a clear if the line is still high.
- R5: Primary positions 6 and 24 never become pending, whatever their input lines do.
- R6: The sub-bits form six groups, each with a fixed parent bit:
  - sub-bits 0–2 → parent 28
  - sub-bits 3–5 → parent 23
  - sub-bits 6–8 → parent 15
  - sub-bits 9–10 → parent 31
  - sub-bits 11–12 → parent 17
  - sub-bits 13–14 → parent 9
- R7: A parent is requested only while its group has a sub-pending bit that is clear in the sub-mask (address 4). The primary input line at a parent position is ignored.
- R8: Interrupt-pending is loaded with the lowest-numbered unmasked pending source, as a one-hot value, only in a cycle when it is empty. It then holds until software clears it. `irq_o` is high exactly when interrupt-pending is non-zero.
- R9: Each register reads back through `reg_rdata` one cycle after its address is presented. The primary mask and the sub-mask read back the value last written to them.
- R10: A sub-line that is high sets its sub-pending bit each cycle. A sub-pending bit is set again after a clear if its line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_lines | input | NUM_SRC | Primary request lines |
| sub_lines | input | 15 | Sub-source request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a selection register that is already occupied while a new source of higher priority arrives. The bench fills the selection register from one source and then pulses a lower-numbered source. It checks that the selection holds, and that the waiting source is taken only after the clear sequence.

The grouped path is covered by sweeping every sub-bit in turn, through sub-pending, parent and selection. The sub-mask is also tested both ways, blocking a sub-bit and then releasing it.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int SUB_W  = 15;
  localparam int N_GRP  = 6;
  localparam int REG_AW = 3;
  localparam int RSVD_A = 6;
  localparam int RSVD_B = 24;

  localparam logic [REG_AW-1:0] A_SRCPND  = 3'd0;
  localparam logic [REG_AW-1:0] A_MASK    = 3'd1;
  localparam logic [REG_AW-1:0] A_INTPND  = 3'd2;
  localparam logic [REG_AW-1:0] A_SUBPND  = 3'd3;
  localparam logic [REG_AW-1:0] A_SUBMASK = 3'd4;

  // sub-bit field owned by group g: three serial groups of 3, then pairs
  function automatic logic [SUB_W-1:0] grp_field(input int g);
    int lo, w;
    logic [31:0] f;
    lo = (g < 3) ? 3 * g : 9 + 2 * (g - 3);
    w  = (g < 3) ? 3 : 2;
    f  = ((32'd1 << w) - 32'd1) << lo;
    return f[SUB_W-1:0];
  endfunction

  function automatic int grp_parent(input int g);
    case (g)
      0: return 28;
      1: return 23;
      2: return 15;
      3: return 31;
      4: return 17;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/cic_sub_layer.sv
module cic_sub_layer
  import cic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SUB_W-1:0] sub_lines,
  input  logic [SUB_W-1:0] sub_clr,
  input  logic             mask_we,
  input  logic [SUB_W-1:0] mask_wdata,
  output logic [SUB_W-1:0] sub_pend,
  output logic [SUB_W-1:0] sub_mask,
  output logic [N_GRP-1:0] grp_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sub_pend <= '0;
      sub_mask <= '1;
    end else begin
      sub_pend <= (sub_pend | sub_lines) & ~sub_clr;
      if (mask_we) sub_mask <= mask_wdata;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_req[g] = |(sub_pend & ~sub_mask & grp_field(g));
  end

  // R2
  sub_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (|sub_clr) |=> ((sub_pend & $past(sub_clr)) == '0));
endmodule

// File: rtl/cic_src_latch.sv
module cic_src_latch #(
  parameter int             N     = 32,
  parameter logic [N-1:0]   LEVEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;
  logic [N-1:0] set_v;

  assign set_v = req & (LEVEL | ~prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= req;
      pend <= (pend | set_v) & ~clr;
    end
  end

  // R4
  edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|(req & ~prev & ~clr)) |=>
      ((pend & $past(req & ~prev & ~clr)) == $past(req & ~prev & ~clr)));
endmodule

// File: rtl/cic_prio_pick.sv
module cic_prio_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] pick
);
  assign pick = cand & (~cand + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/casc_intc.sv
module casc_intc
  import cic_pkg::*;
#(
  parameter int                NUM_SRC   = 32,
  parameter int                DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_SRC = 32'h0000_0030
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] src_lines,
  input  logic [SUB_W-1:0]  sub_lines,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  function automatic logic [NUM_SRC-1:0] parent_bits();
    logic [NUM_SRC-1:0] m;
    m = '0;
    for (int g = 0; g < N_GRP; g++) m[grp_parent(g)] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_SRC-1:0] PARENT_MASK = parent_bits();
  localparam logic [NUM_SRC-1:0] RSVD_MASK =
    (NUM_SRC'(1) << RSVD_A) | (NUM_SRC'(1) << RSVD_B);

  logic [NUM_SRC-1:0] src_pend, int_pend, prim_mask, req_vec, pick;
  logic [NUM_SRC-1:0] clr_src, clr_int;
  logic [SUB_W-1:0]   sub_pend, sub_mask, clr_sub;
  logic [N_GRP-1:0]   grp_req;
  logic [DATA_W-1:0]  rd_mux;

  assign clr_src = (reg_we && reg_addr == A_SRCPND) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign clr_int = (reg_we && reg_addr == A_INTPND) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign clr_sub = (reg_we && reg_addr == A_SUBPND) ? reg_wdata[SUB_W-1:0]   : '0;

  cic_sub_layer u_sub (
    .clk(clk), .rst(rst), .sub_lines(sub_lines), .sub_clr(clr_sub),
    .mask_we(reg_we && reg_addr == A_SUBMASK), .mask_wdata(reg_wdata[SUB_W-1:0]),
    .sub_pend(sub_pend), .sub_mask(sub_mask), .grp_req(grp_req)
  );

  always_comb begin
    req_vec = src_lines & ~PARENT_MASK & ~RSVD_MASK;
    for (int g = 0; g < N_GRP; g++)
      req_vec[grp_parent(g)] = grp_req[g];
  end

  cic_src_latch #(.N(NUM_SRC), .LEVEL(LEVEL_SRC | PARENT_MASK)) u_latch (
    .clk(clk), .rst(rst), .req(req_vec), .clr(clr_src), .pend(src_pend)
  );

  cic_prio_pick #(.N(NUM_SRC)) u_pick (
    .cand(src_pend & ~prim_mask), .pick(pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_mask <= '1;
      int_pend  <= '0;
    end else begin
      if (reg_we && reg_addr == A_MASK) prim_mask <= reg_wdata[NUM_SRC-1:0];
      if (|int_pend) int_pend <= int_pend & ~clr_int;
      else           int_pend <= pick;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_SRCPND:  rd_mux[NUM_SRC-1:0] = src_pend;
      A_MASK:    rd_mux[NUM_SRC-1:0] = prim_mask;
      A_INTPND:  rd_mux[NUM_SRC-1:0] = int_pend;
      A_SUBPND:  rd_mux[SUB_W-1:0]   = sub_pend;
      A_SUBMASK: rd_mux[SUB_W-1:0]   = sub_mask;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq_o = |int_pend;

  // R5
  rsvd_never_chk: assert property (@(posedge clk) disable iff (rst)
    (src_pend & RSVD_MASK) == '0);
  // R8
  intpnd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(int_pend));
  // R8
  intpnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int_pend != '0 && clr_int == '0) |=> (int_pend == $past(int_pend)));
  // R3
  intpnd_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (int_pend == '0) |=> ((int_pend & ~$past(src_pend & ~prim_mask)) == '0));
endmodule

// File: tb/casc_intc_tb.sv
module casc_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_lines = '0;
  logic [14:0] sub_lines = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int n_run = 0, n_fail = 0;
  logic [31:0] v;

  localparam logic [31:0] LVL = 32'h0000_0030;

  casc_intc dut_i (
    .clk(clk), .rst(rst), .src_lines(src_lines), .sub_lines(sub_lines),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  function automatic int parent_of(input int j);
    int g;
    int par[6] = '{28, 23, 15, 31, 17, 9};
    g = (j < 9) ? j / 3 : 3 + (j - 9) / 2;
    return par[g];
  endfunction

  function automatic bit is_parent(input int i);
    return i == 28 || i == 23 || i == 15 || i == 31 || i == 17 || i == 9;
  endfunction

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rchk("R1 mask", 3'd1, 32'hFFFF_FFFF);
    rchk("R1 submask", 3'd4, 32'h0000_7FFF);
    rchk("R1 srcpnd", 3'd0, 32'h0);
    rchk("R1 intpnd", 3'd2, 32'h0);
    rchk("R1 subpnd", 3'd3, 32'h0);

    // R9 mask readback
    wr(3'd1, 32'hA5A5_5A5A);
    rchk("R9 mask rb", 3'd1, 32'hA5A5_5A5A);
    wr(3'd4, 32'h0000_1234);
    rchk("R9 submask rb", 3'd4, 32'h0000_1234);
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h0);

    // primary sweep: R4 R5 R7 R8 R2
    for (int i = 0; i < 32; i++) begin
      src_lines[i] = 1'b1;
      tick();
      if (!LVL[i]) src_lines[i] = 1'b0;
      tick(3);
      if (i == 6 || i == 24) begin
        rchk("R5 reserved", 3'd0, 32'h0);
      end else if (is_parent(i)) begin
        rchk("R7 parent line ignored", 3'd0, 32'h0);
      end else begin
        rchk("R4 srcpnd", 3'd0, 32'h1 << i);
        rchk("R8 intpnd", 3'd2, 32'h1 << i);
        chk("R8 irq high", {31'b0, irq_o}, 32'h1);
        if (LVL[i]) begin
          wr(3'd0, 32'h1 << i);
          tick();
          rchk("R4 level reset", 3'd0, 32'h1 << i);
          src_lines[i] = 1'b0;
        end
        wr(3'd0, 32'h1 << i);
        wr(3'd2, 32'h1 << i);
        tick(2);
        rchk("R2 srcpnd clr", 3'd0, 32'h0);
        rchk("R2 intpnd clr", 3'd2, 32'h0);
        chk("R8 irq low", {31'b0, irq_o}, 32'h0);
      end
      src_lines[i] = 1'b0;
      tick();
    end

    // R4 edge source held high latches once
    src_lines[0] = 1'b1;
    tick(3);
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h1);
    tick(3);
    rchk("R4 edge once", 3'd0, 32'h0);
    src_lines[0] = 1'b0;
    tick();

    // R2 writing zero keeps bits
    src_lines[1] = 1'b1; tick(); src_lines[1] = 1'b0; tick(3);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0);
    rchk("R2 zero write srcpnd", 3'd0, 32'h2);
    rchk("R2 zero write intpnd", 3'd2, 32'h2);
    wr(3'd0, 32'h2); wr(3'd2, 32'h2); tick(2);

    // R3 masking
    wr(3'd1, 32'h8);
    src_lines[3] = 1'b1; tick(); src_lines[3] = 1'b0; tick(3);
    rchk("R3 masked srcpnd", 3'd0, 32'h8);
    rchk("R3 masked intpnd", 3'd2, 32'h0);
    chk("R3 masked irq", {31'b0, irq_o}, 32'h0);
    wr(3'd1, 32'h0);
    tick(2);
    rchk("R3 unmasked intpnd", 3'd2, 32'h8);
    wr(3'd0, 32'h8); wr(3'd2, 32'h8); tick(2);

    // R8 priority and hold
    src_lines[10] = 1'b1; src_lines[20] = 1'b1; tick();
    src_lines = '0; tick(3);
    rchk("R8 lowest first", 3'd2, 32'h400);
    src_lines[2] = 1'b1; tick(); src_lines[2] = 1'b0; tick(3);
    rchk("R8 holds", 3'd2, 32'h400);
    wr(3'd0, 32'h400); wr(3'd2, 32'h400); tick(3);
    rchk("R8 next lowest", 3'd2, 32'h4);
    wr(3'd0, 32'h4); wr(3'd2, 32'h4); tick(3);
    rchk("R8 then 20", 3'd2, 32'h0010_0000);
    wr(3'd0, 32'h0010_0000); wr(3'd2, 32'h0010_0000); tick(2);
    rchk("R8 all clear", 3'd2, 32'h0);

    // sub sweep: R6 R7 R2
    for (int j = 0; j < 15; j++) begin
      int p;
      p = parent_of(j);
      sub_lines[j] = 1'b1; tick(); sub_lines[j] = 1'b0; tick(3);
      rchk("R10 subpnd", 3'd3, 32'h1 << j);
      rchk("R6 parent srcpnd", 3'd0, 32'h1 << p);
      rchk("R6 parent intpnd", 3'd2, 32'h1 << p);
      wr(3'd3, 32'h1 << j);
      wr(3'd0, 32'h1 << p);
      wr(3'd2, 32'h1 << p);
      tick(2);
      rchk("R2 subpnd clr", 3'd3, 32'h0);
      rchk("R2 parent clr", 3'd0, 32'h0);
      chk("R2 irq clr", {31'b0, irq_o}, 32'h0);
    end

    // R10 held sub line sets again after clear
    sub_lines[7] = 1'b1; tick(2);
    wr(3'd3, 32'h80); tick();
    rchk("R10 sub reset", 3'd3, 32'h80);
    sub_lines[7] = 1'b0;
    wr(3'd3, 32'h80); wr(3'd0, 32'h1 << 15); wr(3'd2, 32'h1 << 15); tick(2);

    // R7 sub-mask blocks parent
    wr(3'd4, 32'h7FFF);
    sub_lines[4] = 1'b1; tick(); sub_lines[4] = 1'b0; tick(3);
    rchk("R7 blocked subpnd", 3'd3, 32'h10);
    rchk("R7 blocked parent", 3'd0, 32'h0);
    wr(3'd4, 32'h0); tick(3);
    rchk("R7 released parent", 3'd0, 32'h1 << 23);
    wr(3'd3, 32'h10); wr(3'd0, 32'h1 << 23); wr(3'd2, 32'h1 << 23); tick(2);
    rchk("R7 final clear", 3'd2, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule